// File: doc/BRIEF.md
# Touch ADC SPI Scan Sequencer

This block is an SPI master that runs one scan of an eight-channel touch and housekeeping converter. A start pulse captures a channel-enable mask, a per-channel count of settling samples, a per-channel averaging count and an SCLK divider. The block then sends one continuous chip-select burst. Every enabled channel gets a group of back-to-back 24-bit frames. Each frame is a command byte shifted out, followed by a 16-bit conversion word shifted in.

For each channel the block drops the settling samples and sums the remaining ones. It divides that sum by the averaging count, rounding up, using a small sequential divider. The 12-bit result is presented with its channel index on a one-cycle valid strobe, in rising channel order. A one-cycle done pulse closes the scan. The command byte tells the converter which channel to use and whether the reference is single-ended. It also keeps the converter powered between samples and lets it power down after the last sample of each group.

Top module: `touch_scan_seq`

## Requirements
- R1: Each sample frame is 24 SCLK periods. An 8-bit command goes out on mosi MSB first. Its bit 7 is 1, bits 6:4 carry the channel index and bit 3 is 0. Bits 2 and 1 are both 1 for channels 0, 2, 6 and 7, and both 0 for channels 1, 3, 4 and 5.
- R2: Command bit 0 is 1 on every sample of a channel's group except the final one, where it is 0.
- R3: SPI mode 0 timing. sclk idles low, mosi changes only while sclk is low, and miso is captured on the rising sclk edge. Every sclk high phase lasts exactly sclk_half+1 clk cycles.
- R4: The sample value is bits 14:3 of the 16 bits received MSB first after the command byte. Bit 15 and bits 2:0 are ignored.
- R5: A channel's group holds settle+avg samples sent back to back. The first settle values are dropped, and the result is the sum of the rest divided by avg, rounded up.
- R6: An avg field of 0 behaves as 1.
- R7: Enabled channels are scanned in rising index order, and disabled channels send no frame. Each enabled channel yields exactly one res_valid pulse carrying its index on res_ch.
- R8: cs_n is high whenever busy is low. It stays low from the first frame of a scan through the last result. sclk is low while cs_n is high.
- R9: done pulses for one cycle, exactly one clk cycle after the last res_valid, and busy is low in that cycle.
- R10: A start with an all-zero mask pulses done in the next cycle. It causes no chip-select or sclk activity.
- R11: The mask, counts and divider are captured at start. A start pulse, or any change of these inputs, while busy has no effect on the running scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a scan when idle |
| chan_mask | input | NCH | Channel enables; bit i selects channel i |
| settle_cnt | input | NCH*SKIPW | Settling samples dropped; channel i at bits [i*SKIPW +: SKIPW] |
| avg_cnt | input | NCH*RATW | Averaged samples; channel i at bits [i*RATW +: RATW]; 0 means 1 |
| sclk_half | input | DIVW | sclk half period in clk cycles, minus one |
| miso | input | 1 | Serial data from the converter |
| sclk | output | 1 | SPI clock, mode 0 |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial command to the converter |
| busy | output | 1 | A scan is in progress |
| res_valid | output | 1 | One-cycle strobe for a channel result |
| res_ch | output | $clog2(NCH) | Channel index of the result |
| res_data | output | 12 | Rounded-up average of the kept samples |
| done | output | 1 | One-cycle end-of-scan pulse |

## Verification
The command byte of each frame is due at the eighth rising sclk edge of that frame, so the bench's converter model checks it there. Each reply is driven on the following falling edges and is derived from a bench-side value sequence. Results arrive a data-dependent number of clocks later, so they are compared in order against a queue whenever res_valid is seen. done is due exactly one clock after the last result, or one clock after a start with an empty mask. The sclk high phase must last sclk_half+1 clocks. The bench samples every output on the falling clk edge and checks these rules on every clock.

// File: rtl/tss_pkg.sv
package tss_pkg;
    typedef enum logic [2:0] {
        SEQ_IDLE  = 3'd0,
        SEQ_PICK  = 3'd1,
        SEQ_SHIFT = 3'd2,
        SEQ_DIV   = 3'd3,
        SEQ_FIN   = 3'd4
    } seq_st_e;

    localparam int ATOM_BITS = 24;  // command byte plus 16-bit reply
    localparam int CMD_BITS  = 8;
    localparam int WORD_BITS = ATOM_BITS - CMD_BITS;
    localparam int RES_BITS  = 12;
    localparam int RES_LSB   = 3;   // result sits at bits 14:3 of the reply
endpackage

// File: rtl/tss_cmd_gen.sv
module tss_cmd_gen
    import tss_pkg::*;
#(
    parameter int CHW = 3,
    parameter logic [(1<<CHW)-1:0] SE_MAP = 'hC5
) (
    input  logic [CHW-1:0]      ch,
    input  logic                last,
    output logic [CMD_BITS-1:0] cmd
);
    logic se;

    always_comb begin
        se  = SE_MAP[ch];
        // start bit, address, 12-bit mode, ref select, ref on, converter on
        cmd = {1'b1, 3'(ch), 1'b0, se, se, ~last};
    end
endmodule

// File: rtl/tss_spi_atom.sv
module tss_spi_atom
    import tss_pkg::*;
#(
    parameter int DIVW = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                go,
    input  logic [CMD_BITS-1:0] cmd,
    input  logic [DIVW-1:0]     half_div,
    input  logic                miso,
    output logic                sclk,
    output logic                mosi,
    output logic                done,
    output logic [RES_BITS-1:0] sample
);
    localparam int BCW = $clog2(ATOM_BITS);

    typedef struct packed {
        logic                 act;
        logic                 sclk;
        logic                 done;
        logic [BCW-1:0]       bitn;
        logic [DIVW-1:0]      tcnt;
        logic [ATOM_BITS-1:0] tx;
        logic [WORD_BITS-1:0] rx;
    } atom_s;

    atom_s at_q, at_d;

    always_comb begin
        at_d      = at_q;
        at_d.done = 1'b0;
        if (go) begin
            at_d.act  = 1'b1;
            at_d.sclk = 1'b0;
            at_d.bitn = '0;
            at_d.tcnt = '0;
            at_d.tx   = {cmd, {WORD_BITS{1'b0}}};
            at_d.rx   = '0;
        end else if (at_q.act) begin
            if (at_q.tcnt == half_div) begin
                at_d.tcnt = '0;
                if (!at_q.sclk) begin
                    at_d.sclk = 1'b1;
                    at_d.rx   = {at_q.rx[WORD_BITS-2:0], miso};
                end else begin
                    at_d.sclk = 1'b0;
                    at_d.tx   = {at_q.tx[ATOM_BITS-2:0], 1'b0};
                    if (at_q.bitn == BCW'(ATOM_BITS - 1)) begin
                        at_d.act  = 1'b0;
                        at_d.done = 1'b1;
                    end else begin
                        at_d.bitn = at_q.bitn + 1'b1;
                    end
                end
            end else begin
                at_d.tcnt = at_q.tcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) at_q <= '0;
        else        at_q <= at_d;
    end

    assign sclk   = at_q.sclk;
    assign mosi   = at_q.tx[ATOM_BITS-1];
    assign done   = at_q.done;
    assign sample = at_q.rx[RES_LSB +: RES_BITS];
endmodule

// File: rtl/tss_ceil_div.sv
module tss_ceil_div #(
    parameter int NW = 16,
    parameter int DW = 4,
    parameter int QW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [NW-1:0] num,
    input  logic [DW-1:0] den,
    output logic          done,
    output logic [QW-1:0] quo
);
    localparam int XW  = NW + 1;          // room for num + den - 1
    localparam int SCW = $clog2(XW + 1);

    typedef struct packed {
        logic           act;
        logic           done;
        logic [SCW-1:0] cnt;
        logic [DW-1:0]  rem;
        logic [DW-1:0]  dv;
        logic [XW-1:0]  qt;
    } div_s;

    div_s dv_q, dv_d;
    logic [DW:0] rsh;

    always_comb begin
        dv_d      = dv_q;
        dv_d.done = 1'b0;
        rsh       = {dv_q.rem, dv_q.qt[XW-1]};
        if (go) begin
            dv_d.act = 1'b1;
            dv_d.cnt = '0;
            dv_d.rem = '0;
            dv_d.dv  = den;
            dv_d.qt  = XW'(num) + XW'(den) - XW'(1);
        end else if (dv_q.act) begin
            if (rsh >= {1'b0, dv_q.dv}) begin
                dv_d.rem = DW'(rsh - {1'b0, dv_q.dv});
                dv_d.qt  = {dv_q.qt[XW-2:0], 1'b1};
            end else begin
                dv_d.rem = rsh[DW-1:0];
                dv_d.qt  = {dv_q.qt[XW-2:0], 1'b0};
            end
            if (dv_q.cnt == SCW'(XW - 1)) begin
                dv_d.act  = 1'b0;
                dv_d.done = 1'b1;
            end else begin
                dv_d.cnt = dv_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dv_q <= '0;
        else        dv_q <= dv_d;
    end

    assign done = dv_q.done;
    assign quo  = dv_q.qt[QW-1:0];
endmodule

// File: rtl/touch_scan_seq.sv
module touch_scan_seq
    import tss_pkg::*;
#(
    parameter int NCH   = 8,
    parameter int SKIPW = 4,
    parameter int RATW  = 4,
    parameter int DIVW  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [NCH-1:0]            chan_mask,
    input  logic [NCH*SKIPW-1:0]      settle_cnt,
    input  logic [NCH*RATW-1:0]       avg_cnt,
    input  logic [DIVW-1:0]           sclk_half,
    input  logic                      miso,
    output logic                      sclk,
    output logic                      cs_n,
    output logic                      mosi,
    output logic                      busy,
    output logic                      res_valid,
    output logic [$clog2(NCH)-1:0]    res_ch,
    output logic [RES_BITS-1:0]       res_data,
    output logic                      done
);
    localparam int CHW  = $clog2(NCH);
    localparam int ACCW = RES_BITS + RATW;
    localparam int CNTW = ((SKIPW > RATW) ? SKIPW : RATW) + 1;

    typedef struct packed {
        seq_st_e              st;
        logic [NCH-1:0]       mask;
        logic [NCH*SKIPW-1:0] skips;
        logic [NCH*RATW-1:0]  ratios;
        logic [DIVW-1:0]      hdiv;
        logic [CHW-1:0]       ch;
        logic [CNTW-1:0]      cnt;
        logic [ACCW-1:0]      acc;
        logic                 cs_n;
        logic                 go;
        logic                 dgo;
        logic                 rvalid;
        logic [CHW-1:0]       rch;
        logic [RES_BITS-1:0]  rdata;
        logic                 done;
    } seq_s;

    seq_s sq_q, sq_d;

    logic [SKIPW-1:0]    skip_a [NCH];
    logic [RATW-1:0]     rat_a  [NCH];
    logic [SKIPW-1:0]    cur_skip;
    logic [RATW-1:0]     cur_rat;
    logic [CNTW-1:0]     grp_len;
    logic                grp_last;
    logic                hi_rest;
    logic [ACCW-1:0]     acc_n;
    logic [CMD_BITS-1:0] cmd_w;
    logic                at_done;
    logic [RES_BITS-1:0] at_sample;
    logic                dv_done;
    logic [RES_BITS-1:0] dv_quo;

    // per-channel view of the captured configuration; zero average count means one
    for (genvar gi = 0; gi < NCH; gi++) begin : g_cfg
        assign skip_a[gi] = sq_q.skips[gi*SKIPW +: SKIPW];
        assign rat_a[gi]  = (sq_q.ratios[gi*RATW +: RATW] == '0) ?
                            RATW'(1) : sq_q.ratios[gi*RATW +: RATW];
    end

    assign cur_skip = skip_a[sq_q.ch];
    assign cur_rat  = rat_a[sq_q.ch];
    assign grp_len  = CNTW'(cur_skip) + CNTW'(cur_rat);
    assign grp_last = (sq_q.cnt == grp_len - 1'b1);
    assign hi_rest  = |(sq_q.mask >> (int'(sq_q.ch) + 1));

    tss_cmd_gen #(.CHW(CHW)) cmd_i (
        .ch   (sq_q.ch),
        .last (grp_last),
        .cmd  (cmd_w)
    );

    tss_spi_atom #(.DIVW(DIVW)) atom_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (sq_q.go),
        .cmd      (cmd_w),
        .half_div (sq_q.hdiv),
        .miso     (miso),
        .sclk     (sclk),
        .mosi     (mosi),
        .done     (at_done),
        .sample   (at_sample)
    );

    tss_ceil_div #(.NW(ACCW), .DW(RATW), .QW(RES_BITS)) div_i (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (sq_q.dgo),
        .num   (sq_q.acc),
        .den   (cur_rat),
        .done  (dv_done),
        .quo   (dv_quo)
    );

    always_comb begin
        sq_d        = sq_q;
        sq_d.go     = 1'b0;
        sq_d.dgo    = 1'b0;
        sq_d.rvalid = 1'b0;
        sq_d.done   = 1'b0;
        acc_n       = '0;
        case (sq_q.st)
            SEQ_IDLE: begin
                if (start) begin
                    if (chan_mask == '0) begin
                        sq_d.done = 1'b1;
                    end else begin
                        sq_d.st     = SEQ_PICK;
                        sq_d.mask   = chan_mask;
                        sq_d.skips  = settle_cnt;
                        sq_d.ratios = avg_cnt;
                        sq_d.hdiv   = sclk_half;
                        sq_d.ch     = '0;
                    end
                end
            end
            SEQ_PICK: begin
                if (sq_q.mask[sq_q.ch]) begin
                    sq_d.st   = SEQ_SHIFT;
                    sq_d.cnt  = '0;
                    sq_d.acc  = '0;
                    sq_d.go   = 1'b1;
                    sq_d.cs_n = 1'b0;
                end else begin
                    sq_d.ch = sq_q.ch + 1'b1;
                end
            end
            SEQ_SHIFT: begin
                if (at_done) begin
                    acc_n    = sq_q.acc + ((sq_q.cnt >= CNTW'(cur_skip)) ?
                                           ACCW'(at_sample) : ACCW'(0));
                    sq_d.acc = acc_n;
                    if (grp_last) begin
                        sq_d.st  = SEQ_DIV;
                        sq_d.dgo = 1'b1;
                    end else begin
                        sq_d.cnt = sq_q.cnt + 1'b1;
                        sq_d.go  = 1'b1;
                    end
                end
            end
            SEQ_DIV: begin
                if (dv_done) begin
                    sq_d.rvalid = 1'b1;
                    sq_d.rch    = sq_q.ch;
                    sq_d.rdata  = dv_quo;
                    if (hi_rest) begin
                        sq_d.ch = sq_q.ch + 1'b1;
                        sq_d.st = SEQ_PICK;
                    end else begin
                        sq_d.st = SEQ_FIN;
                    end
                end
            end
            SEQ_FIN: begin
                sq_d.done = 1'b1;
                sq_d.cs_n = 1'b1;
                sq_d.st   = SEQ_IDLE;
            end
            default: sq_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq_q      <= '0;
            sq_q.cs_n <= 1'b1;
        end else begin
            sq_q <= sq_d;
        end
    end

    assign cs_n      = sq_q.cs_n;
    assign busy      = (sq_q.st != SEQ_IDLE);
    assign res_valid = sq_q.rvalid;
    assign res_ch    = sq_q.rch;
    assign res_data  = sq_q.rdata;
    assign done      = sq_q.done;
endmodule

// File: rtl/touch_scan_seq_chk.sv
module touch_scan_seq_chk #(
    parameter int NCH = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic [NCH-1:0] chan_mask,
    input logic           sclk,
    input logic           cs_n,
    input logic           mosi,
    input logic           busy,
    input logic           res_valid,
    input logic           done
);
    AST_CS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> cs_n);  // R8

    AST_SCLK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);  // R8

    AST_CS_HELD_AT_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !cs_n);  // R8

    AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> $stable(mosi));  // R3

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);  // R9

    AST_EMPTY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && chan_mask == '0) |=> (done && cs_n));  // R10
endmodule

bind touch_scan_seq touch_scan_seq_chk #(.NCH(NCH)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .chan_mask (chan_mask),
    .sclk      (sclk),
    .cs_n      (cs_n),
    .mosi      (mosi),
    .busy      (busy),
    .res_valid (res_valid),
    .done      (done)
);

// File: tb/touch_scan_seq_tb_top.sv
module touch_scan_seq_tb_top;
    localparam int NCH = 8, SKIPW = 4, RATW = 4, DIVW = 8;

    logic clk = 1'b0;
    always #10 clk = ~clk;  // 50 MHz

    logic                 rst_n = 1'b0;
    logic                 start = 1'b0;
    logic [NCH-1:0]       chan_mask = '0;
    logic [NCH*SKIPW-1:0] settle_cnt = '0;
    logic [NCH*RATW-1:0]  avg_cnt = '0;
    logic [DIVW-1:0]      sclk_half = '0;
    logic                 miso = 1'b0;
    logic sclk, cs_n, mosi, busy, res_valid, done;
    logic [2:0]  res_ch;
    logic [11:0] res_data;

    touch_scan_seq #(.NCH(NCH), .SKIPW(SKIPW), .RATW(RATW), .DIVW(DIVW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .chan_mask(chan_mask),
        .settle_cnt(settle_cnt), .avg_cnt(avg_cnt), .sclk_half(sclk_half),
        .miso(miso), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .busy(busy),
        .res_valid(res_valid), .res_ch(res_ch), .res_data(res_data), .done(done)
    );

    int n_tests = 0, n_fail = 0;
    int seed_b = 1, atom_k = 0, cur_div = 0, cyc = 0, hi_run = 0;
    bit done_seen = 0, prev_valid = 0, want_prev_valid = 0, prev_sclk = 0;
    string cur_tag = "";
    logic [7:0]  exp_cmd_q [$];
    logic [14:0] exp_res_q [$];
    logic [7:0]  e_cmd;
    logic [14:0] e_res;

    function automatic logic [11:0] gen(int s, int k);
        if (s == 0) return 12'hFFF;
        return 12'((s * 1237 + k * 389 + k * k * 7) % 4096);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // converter model: reset bit count when selected, capture command, reply
    int bitcnt = 0;
    logic [7:0]  cmd_sh = '0;
    logic [23:0] frame = '0;
    always @(negedge cs_n) bitcnt = 0;
    always @(posedge sclk) begin
        if (bitcnt < 8) cmd_sh = {cmd_sh[6:0], mosi};
        bitcnt++;
        if (bitcnt == 8) begin
            if (exp_cmd_q.size() == 0) begin
                check(0, "R7 frame for no enabled sample", int'(cmd_sh), 0);
            end else begin
                e_cmd = exp_cmd_q.pop_front();
                check(cmd_sh == e_cmd, "R1 R2 command byte", int'(cmd_sh), int'(e_cmd));
            end
            // bit 15 and bits 2:0 of the reply carry junk, which must be ignored (R4)
            frame  = {8'h00, 1'b1, gen(seed_b, atom_k), 3'b101};
            atom_k++;
        end
        if (bitcnt == 24) bitcnt = 0;
    end
    always @(negedge sclk) miso = frame[23 - bitcnt];

    // per-clock comparison against the bench's expectations
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            check(busy || cs_n, "R8 cs_n low while idle", int'(cs_n), 1);
            if (cs_n) check(!sclk, "R8 sclk active without select", int'(sclk), 0);
            if (sclk) hi_run++;
            else begin
                if (prev_sclk) check(hi_run == cur_div + 1, "R3 sclk high width", hi_run, cur_div + 1);
                hi_run = 0;
            end
            prev_sclk = sclk;
            if (res_valid) begin
                if (exp_res_q.size() == 0) begin
                    check(0, "R7 extra result", int'(res_ch), 0);
                end else begin
                    e_res = exp_res_q.pop_front();
                    check(res_ch == e_res[14:12], {"R7 channel order ", cur_tag},
                          int'(res_ch), int'(e_res[14:12]));
                    check(res_data == e_res[11:0], {"R4 R5 result ", cur_tag},
                          int'(res_data), int'(e_res[11:0]));
                end
            end
            if (done) begin
                done_seen = 1;
                check(exp_res_q.size() == 0, "R9 done before all results", exp_res_q.size(), 0);
                if (want_prev_valid)
                    check(prev_valid, "R9 done one cycle after last result", int'(prev_valid), 1);
                check(!busy, "R9 busy low at done", int'(busy), 0);
            end
            prev_valid = res_valid;
            if (cyc > 150000) begin
                check(0, "watchdog expired", cyc, 150000);
                finish_run();
            end
        end
    end

    task automatic run_scan(logic [7:0] m, int sk[8], int ra[8], int dv, int sd, string tag);
        int k = 0;
        seed_b = sd; atom_k = 0; cur_div = dv; cur_tag = tag;
        for (int ch = 0; ch < 8; ch++) begin
            if (m[ch]) begin
                int r = (ra[ch] == 0) ? 1 : ra[ch];
                int n = sk[ch] + r;
                int sum = 0;
                bit se = (ch == 0 || ch == 2 || ch == 6 || ch == 7);
                for (int s = 0; s < n; s++) begin
                    exp_cmd_q.push_back(8'h80 | 8'(ch << 4) | (se ? 8'h06 : 8'h00) |
                                        ((s == n - 1) ? 8'h00 : 8'h01));
                    if (s >= sk[ch]) sum += int'(gen(sd, k));
                    k++;
                end
                exp_res_q.push_back({3'(ch), 12'((sum + r - 1) / r)});
            end
        end
        chan_mask = m;
        for (int i = 0; i < 8; i++) begin
            settle_cnt[i*SKIPW +: SKIPW] = 4'(sk[i]);
            avg_cnt[i*RATW +: RATW]      = 4'(ra[i]);
        end
        sclk_half = 8'(dv);
        done_seen = 0;
        want_prev_valid = (m != 0);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        while (!done_seen) @(negedge clk);
        check(exp_cmd_q.size() == 0, {"R7 all frames sent ", tag}, exp_cmd_q.size(), 0);
    endtask

    initial begin
        int sk1[8] = '{1, 1, 1, 1, 1, 1, 1, 1};
        int ra1[8] = '{1, 1, 1, 1, 1, 1, 1, 1};
        int skb[8] = '{0, 2, 3, 1, 0, 2, 1, 3};
        int rab[8] = '{2, 3, 5, 1, 4, 7, 2, 6};
        int skc[8] = '{2, 0, 0, 0, 0, 0, 0, 2};
        int rac[8] = '{0, 1, 1, 1, 1, 1, 1, 15};
        int skd[8] = '{0, 0, 0, 1, 2, 0, 0, 0};
        int rad[8] = '{1, 1, 1, 3, 4, 1, 1, 1};
        int skf[8] = '{3, 3, 3, 3, 3, 3, 3, 3};
        int raf[8] = '{8, 8, 8, 8, 8, 8, 8, 8};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state (R8)
        check(cs_n == 1'b1, "R8 reset cs_n", int'(cs_n), 1);
        check(sclk == 1'b0, "R8 reset sclk", int'(sclk), 0);
        check(busy == 1'b0 && done == 1'b0 && res_valid == 1'b0, "R8 reset idle outputs",
              int'({busy, done, res_valid}), 0);

        // R1 R2 R7: all channels, one settle, single sample, fastest clock
        run_scan(8'hFF, sk1, ra1, 0, 3, "R7 base");
        // R5: mixed counts and rounding
        run_scan(8'hA6, skb, rab, 2, 7, "R5 mixed");
        // R6: zero average count, and full-scale sum at the largest count
        run_scan(8'h81, skc, rac, 1, 0, "R6 zero ratio");
        // R5 ceiling on middle channels, R3 slower clock
        run_scan(8'h18, skd, rad, 3, 11, "R5 ceil");

        // R10: empty mask
        chan_mask = '0;
        done_seen = 0;
        want_prev_valid = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        check(done == 1'b1, "R10 done after empty start", int'(done), 1);
        check(cs_n == 1'b1 && busy == 1'b0, "R10 no select on empty scan", int'({cs_n, busy}), 2);
        repeat (3) @(negedge clk);
        check(cs_n == 1'b1 && sclk == 1'b0 && busy == 1'b0, "R10 stays idle",
              int'({cs_n, sclk, busy}), 4);

        // R11: second start and changed inputs while busy
        fork
            run_scan(8'h5A, skf, raf, 1, 5, "R11 restart ignored");
            begin
                repeat (300) @(negedge clk);
                check(busy == 1'b1, "R11 scan busy at injection", int'(busy), 1);
                start = 1'b1; chan_mask = 8'hFF; settle_cnt = '0; avg_cnt = '1; sclk_half = 8'd5;
                @(negedge clk) start = 1'b0;
            end
        join
        repeat (5) @(negedge clk);
        check(busy == 1'b0, "R11 no second scan", int'(busy), 0);
        finish_run();
    end
endmodule